// File: doc/BRIEF.md
# ADC Scan Result Address Generator

This block sits between a channel-scanning analog-to-digital converter and a word-wide memory write port. It tells the converter which analog input to sample next. It walks the enabled inputs of a channel mask in ascending order and wraps from the highest enabled input back to the lowest. Every finished conversion is turned into one full-word memory write. The write is placed at a base address plus an offset, and the offset comes from one of two addressing schemes.

In sequential mode the offset is the number of conversions taken since the block started. In channel-indexed mode each input owns a fixed group of slots. The offset is the input number times the slots per input, plus the index of the current sweep through the mask. After a programmed number of conversions the block raises a one-cycle completion pulse and starts a new block.

Results enter on a valid/ready stream and writes leave on another valid/ready stream, with one register stage between them. A result is taken only when that stage is empty or is draining in the same cycle. A stalled write therefore stops the converter stream rather than dropping data. Configuration inputs are expected to stay steady during a block.

Top module: `adc_scan_addr_gen`

## Requirements
- R1: `adc_ch` always names an enabled input while `ch_mask` is non-zero. Inputs are visited in ascending order, and after the highest enabled input the scan returns to the lowest enabled one.
- R2: When `seq_mode` is 1, the write offset equals the number of results accepted since the block began: 0, 1, 2 and so on.
- R3: When `seq_mode` is 0, the write offset equals channel × S + sweep. S is `slots_per_ch`, and a value of 0 counts as 1. The sweep index starts at 0 and steps by one, modulo S, each time the scan wraps from the highest enabled input to the lowest.
- R4: Each accepted result produces exactly one write. Its address is `base_addr` + offset, modulo 2^ADDR_W, and its data equals the result unchanged.
- R5: `blk_done` is high for exactly the cycle in which the write of the result numbered `blk_len` in the block is handshaken (a `blk_len` of 0 counts as 1). The next result then uses offset 0 in sequential mode, sweep 0, and the lowest enabled input.
- R6: While `wr_valid` is high and `wr_ready` is low, `res_ready` is low and `wr_addr` and `wr_data` hold steady.
- R7: With `ch_mask` all zeros, results are accepted and discarded. No write is issued and `blk_done` stays low.
- R8: After reset, `wr_valid` and `blk_done` are low, `res_ready` is high, and `adc_ch` names the lowest enabled input.
- R9: `blk_done` is never high unless a write handshake (`wr_valid` and `wr_ready`) happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_mask | input | NUM_CH | Enabled analog inputs, bit i = input i |
| seq_mode | input | 1 | 1 = sequential offsets, 0 = channel-indexed offsets |
| slots_per_ch | input | SLOT_W | Slots reserved per input in channel-indexed mode (0 acts as 1) |
| blk_len | input | CNT_W | Conversions per block (0 acts as 1) |
| base_addr | input | ADDR_W | Buffer base word address |
| adc_ch | output | CH_W | Input the next accepted result belongs to |
| res_valid | input | 1 | Conversion result present |
| res_ready | output | 1 | Result accepted when high together with res_valid |
| res_data | input | DATA_W | Conversion result |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory port takes the write |
| wr_addr | output | ADDR_W | Write word address |
| wr_data | output | DATA_W | Write data word |
| blk_done | output | 1 | One-cycle block completion pulse |

## Verification
The assertions check stream behaviour on every cycle. Back-pressure must hold the write steady and stall the input. The completion pulse must coincide with a write handshake. An all-zero mask must never start a write, and the named channel must always be an enabled one. Only the bench scenarios can show that the offsets are arithmetically correct in both modes. Those scenarios also cover the order of the sweep wrap across many masks, slot counts and block lengths, the point where a block ends and restarts, and wrap-around of the base-plus-offset address.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic {
    MODE_CHAN_INDEXED = 1'b0,
    MODE_SEQUENTIAL   = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] mask,
  input  logic              step,
  input  logic              restart,
  output logic [CH_W-1:0]   cur_ch,
  output logic              wrap,
  output logic              any_en
);
  logic [CH_W-1:0] pos_q;
  logic [CH_W-1:0] lowest;
  logic [CH_W-1:0] eff;
  logic [CH_W-1:0] nxt;
  logic [CH_W:0]   above_pos;
  logic [CH_W:0]   above_eff;

  // {found, index} of the first set bit strictly above x
  function automatic logic [CH_W:0] first_above(input logic [NUM_CH-1:0] m,
                                                input logic [CH_W-1:0]   x);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i] && (i > int'(x))) r = {1'b1, CH_W'(i)};
    end
    return r;
  endfunction

  always_comb begin
    lowest = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) lowest = CH_W'(i);
    end
  end

  assign any_en    = |mask;
  assign above_pos = first_above(mask, pos_q);
  assign eff       = mask[pos_q] ? pos_q : (above_pos[CH_W] ? above_pos[CH_W-1:0] : lowest);
  assign above_eff = first_above(mask, eff);
  assign wrap      = ~above_eff[CH_W];
  assign nxt       = wrap ? lowest : above_eff[CH_W-1:0];
  assign cur_ch    = eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (step) begin
      pos_q <= restart ? '0 : nxt;
    end
  end
endmodule

// File: rtl/step_counters.sv
module step_counters #(
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wrap,
  input  logic [SLOT_W-1:0] slots,
  input  logic [CNT_W-1:0]  blen,
  output logic [CNT_W-1:0]  conv_cnt,
  output logic [SLOT_W-1:0] sweep,
  output logic [SLOT_W-1:0] slots_eff,
  output logic              last
);
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] sweep_q;
  logic [CNT_W-1:0]  blen_eff;
  logic [SLOT_W:0]   sweep_inc;

  assign slots_eff = (slots == '0) ? SLOT_W'(1) : slots;
  assign blen_eff  = (blen == '0) ? CNT_W'(1) : blen;
  assign last      = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, blen_eff};
  assign sweep_inc = {1'b0, sweep_q} + (SLOT_W+1)'(1);
  assign conv_cnt  = cnt_q;
  assign sweep     = sweep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sweep_q <= '0;
    end else if (step) begin
      if (last) begin
        cnt_q   <= '0;
        sweep_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (wrap) begin
          sweep_q <= (sweep_inc >= {1'b0, slots_eff}) ? '0 : sweep_inc[SLOT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/offset_unit.sv
module offset_unit
  import adc_scan_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input  addr_mode_e        mode,
  input  logic [CH_W-1:0]   ch,
  input  logic [SLOT_W-1:0] slots,
  input  logic [SLOT_W-1:0] sweep,
  input  logic [CNT_W-1:0]  conv_cnt,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);
  localparam int IDX_W = CH_W + SLOT_W;
  localparam int OFF_W = (CNT_W > IDX_W) ? CNT_W : IDX_W;

  logic [OFF_W-1:0] chan_off;
  logic [OFF_W-1:0] seq_off;
  logic [OFF_W-1:0] off;

  assign chan_off = OFF_W'(ch) * OFF_W'(slots) + OFF_W'(sweep);
  assign seq_off  = OFF_W'(conv_cnt);

  generate
    if (OFF_W >= ADDR_W) begin : g_trunc
      always_comb begin
        off  = (mode == MODE_SEQUENTIAL) ? seq_off : chan_off;
        addr = base + off[ADDR_W-1:0];
      end
    end else begin : g_ext
      always_comb begin
        off  = (mode == MODE_SEQUENTIAL) ? seq_off : chan_off;
        addr = base + ADDR_W'(off);
      end
    end
  endgenerate
endmodule

// File: rtl/adc_scan_addr_gen.sv
module adc_scan_addr_gen
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic              seq_mode,
  input  logic [SLOT_W-1:0] slots_per_ch,
  input  logic [CNT_W-1:0]  blk_len,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [CH_W-1:0]   adc_ch,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              blk_done
);
  logic              accept;
  logic              step;
  logic              wrap;
  logic              any_en;
  logic              last;
  logic [CH_W-1:0]   cur_ch;
  logic [CNT_W-1:0]  conv_cnt;
  logic [SLOT_W-1:0] sweep;
  logic [SLOT_W-1:0] slots_eff;
  logic [ADDR_W-1:0] next_addr;
  addr_mode_e        mode;

  logic              wv_q;
  logic              wlast_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  assign mode      = addr_mode_e'(seq_mode);
  assign res_ready = ~wv_q | wr_ready;
  assign accept    = res_valid & res_ready;
  assign step      = accept & any_en;

  scan_sequencer #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask    (ch_mask),
    .step    (step),
    .restart (last),
    .cur_ch  (cur_ch),
    .wrap    (wrap),
    .any_en  (any_en)
  );

  step_counters #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .wrap      (wrap),
    .slots     (slots_per_ch),
    .blen      (blk_len),
    .conv_cnt  (conv_cnt),
    .sweep     (sweep),
    .slots_eff (slots_eff),
    .last      (last)
  );

  offset_unit #(.CH_W(CH_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_off (
    .mode     (mode),
    .ch       (cur_ch),
    .slots    (slots_eff),
    .sweep    (sweep),
    .conv_cnt (conv_cnt),
    .base     (base_addr),
    .addr     (next_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wv_q    <= 1'b0;
      wlast_q <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (step) begin
      wv_q    <= 1'b1;
      wlast_q <= last;
      waddr_q <= next_addr;
      wdata_q <= res_data;
    end else if (wr_ready) begin
      wv_q    <= 1'b0;
      wlast_q <= 1'b0;
    end
  end

  assign adc_ch   = cur_ch;
  assign wr_valid = wv_q;
  assign wr_addr  = waddr_q;
  assign wr_data  = wdata_q;
  assign blk_done = wv_q & wr_ready & wlast_q;
endmodule

// File: rtl/adc_scan_addr_gen_sva.sv
module adc_scan_addr_gen_sva #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_mask,
  input logic [CH_W-1:0]   adc_ch,
  input logic              res_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              blk_done
);
  // R6: a stalled write stays put
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R6: no intake while the write stage is blocked
  a_r6_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !res_ready);

  // R9: completion only with a write handshake
  a_r9_done_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> (wr_valid && wr_ready));

  // R7: empty mask never starts a write
  a_r7_empty_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_mask == '0 && !wr_valid) |=> !wr_valid);

  // R1: named input is enabled
  a_r1_channel_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_mask != '0) |-> ch_mask[adc_ch]);
endmodule

bind adc_scan_addr_gen adc_scan_addr_gen_sva #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_mask   (ch_mask),
  .adc_ch    (adc_ch),
  .res_ready (res_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .blk_done  (blk_done)
);

// File: tb/sim_adc_scan_addr_gen.sv
module sim_adc_scan_addr_gen;
  localparam int NUM_CH = 16;
  localparam int SLOT_W = 3;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] ch_mask = '0;
  logic              seq_mode = 1'b0;
  logic [SLOT_W-1:0] slots_per_ch = '0;
  logic [CNT_W-1:0]  blk_len = '0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [3:0]        adc_ch;
  logic              res_valid = 1'b0;
  logic              res_ready;
  logic [DATA_W-1:0] res_data = '0;
  logic              wr_valid;
  logic              wr_ready = 1'b1;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              blk_done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  adc_scan_addr_gen #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
                      .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_mask(ch_mask), .seq_mode(seq_mode),
    .slots_per_ch(slots_per_ch), .blk_len(blk_len), .base_addr(base_addr),
    .adc_ch(adc_ch), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .blk_done(blk_done));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    res_valid = 1'b0;
    wr_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One configuration: nres results, result number stall_at held back by the write port
  task automatic run_cfg(input logic [15:0] m, input bit sm, input int sl,
                         input int bl, input int base, input int nres,
                         input int stall_at);
    int en[16];
    int n = 0;
    int j = 0;
    int s = 0;
    int c = 0;
    int seff = (sl == 0) ? 1 : sl;
    int beff = (bl == 0) ? 1 : bl;
    for (int i = 0; i < 16; i++) if (m[i]) begin en[n] = i; n++; end
    ch_mask = m; seq_mode = sm; slots_per_ch = SLOT_W'(sl);
    blk_len = CNT_W'(bl); base_addr = ADDR_W'(base);
    do_reset();
    #1;
    chk("R8 wr_valid", int'(wr_valid), 0);
    chk("R8 blk_done", int'(blk_done), 0);
    chk("R8 res_ready", int'(res_ready), 1);
    if (n > 0) chk("R8 adc_ch", int'(adc_ch), en[0]);
    for (int k = 0; k < nres; k++) begin
      int ch; int off; int exp_addr; bit lst; int d;
      @(negedge clk);
      d = (k * 37 + 5) & 12'hFFF;
      res_valid = 1'b1;
      res_data  = DATA_W'(d);
      if (n == 0) begin
        #1 chk("R7 res_ready", int'(res_ready), 1);
        @(negedge clk);
        res_valid = 1'b0;
        #1 chk("R7 wr_valid", int'(wr_valid), 0);
        chk("R7 blk_done", int'(blk_done), 0);
        continue;
      end
      ch  = en[j];
      off = sm ? c : ch * seff + s;
      exp_addr = (base + off) & 16'hFFFF;
      lst = (c + 1 >= beff);
      #1 chk("R1 adc_ch", int'(adc_ch), ch);
      if (k == stall_at) wr_ready = 1'b0;
      @(negedge clk);
      res_valid = 1'b0;
      #1;
      chk("R4 wr_valid", int'(wr_valid), 1);
      chk(sm ? "R2 wr_addr" : "R3 wr_addr", int'(wr_addr), exp_addr);
      chk("R4 wr_data", int'(wr_data), d);
      if (k == stall_at) begin
        for (int w = 0; w < 3; w++) begin
          @(negedge clk); #1;
          chk("R6 res_ready", int'(res_ready), 0);
          chk("R6 wr_valid", int'(wr_valid), 1);
          chk("R6 wr_addr", int'(wr_addr), exp_addr);
          chk("R6 blk_done", int'(blk_done), 0);
        end
        wr_ready = 1'b1;
        #1;
      end
      chk("R5 blk_done", int'(blk_done), int'(lst));
      @(negedge clk); #1;
      chk("R4 single write", int'(wr_valid), 0);
      if (lst) begin j = 0; s = 0; c = 0; end
      else begin
        c++;
        if (j == n - 1) begin j = 0; s = (s + 1) % seff; end
        else j++;
      end
    end
  endtask

  initial begin
    // example scan set, both modes, several slot counts and block lengths
    run_cfg(16'h1C33, 1'b1, 1, 7, 16'h0100, 16, 3);
    run_cfg(16'h1C33, 1'b0, 1, 7, 16'h0100, 16, -1);
    run_cfg(16'h1C33, 1'b0, 4, 28, 16'h0200, 30, 10);
    run_cfg(16'h1C33, 1'b1, 4, 28, 16'h0000, 30, -1);
    run_cfg(16'h1C33, 1'b0, 3, 10, 16'h0040, 25, -1);
    // single high input, slot count 0 and block length 0
    run_cfg(16'h8000, 1'b0, 0, 0, 16'h0010, 6, 2);
    run_cfg(16'h8000, 1'b0, 7, 20, 16'hFFF0, 22, -1);
    // all inputs, address wrap at the top of the space
    run_cfg(16'hFFFF, 1'b1, 2, 40, 16'hFFFC, 45, 5);
    run_cfg(16'hFFFF, 1'b0, 2, 40, 16'hFFF8, 45, -1);
    // sparse masks, sweep over slot counts
    for (int sl = 1; sl < 8; sl++) begin
      run_cfg(16'hA005, 1'b0, sl, 3 * sl + 1, 16'h0300, 3 * sl + 4, -1);
      run_cfg(16'h0421, 1'b1, sl, sl + 2, 16'h0300, 2 * sl + 5, -1);
    end
    // empty mask drops results
    run_cfg(16'h0000, 1'b0, 2, 3, 16'h0000, 5, -1);
    run_cfg(16'h0000, 1'b1, 2, 1, 16'h0000, 3, -1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule